// File: doc/BRIEF.md
# Dual DAC serial command decoder

This block is the digital control core of a two-channel, 16-bit converter. Write frames arrive on an SPI-style serial port: a frame-sync line that is active low, a serial clock, and a data line. The block collects one 24-bit word per frame and decodes it. A register-select field picks the function, data or coarse-gain register. A channel field picks channel A, channel B or both. Each channel keeps two code registers. The input register is staged and takes data writes. The DAC register drives the converter and changes only on load or clear. Each channel also has a 2-bit coarse-gain register.

A function register holds six configuration bits: a local-ground-offset enable, direction and value for two general-purpose pins, and a disable for the serial data output. The function register also carries a load command and a clear command. A coding input selects twos-complement or straight-binary interpretation. The DAC register contents are presented to the converter as straight-binary codes, so the same cleared register contents mean 0 V in one coding and negative full scale in the other.

The serial receiver is a four-state machine. RX_IDLE moves to RX_SHIFT when frame sync falls. RX_SHIFT moves to RX_COMMIT when frame sync rises after exactly 24 serial clocks, and to RX_DROP when frame sync rises after any other count. RX_COMMIT and RX_DROP both return to RX_IDLE after one cycle. RX_COMMIT is the only state in which a command is applied.

Top module: `dac_cmd_core`

## Requirements
- R1: A frame is shifted in MSB first, one bit per falling edge of `spi_sclk_i`, while `spi_sync_n_i` is low. The frame is acted on when `spi_sync_n_i` rises, and only if exactly 24 bits were shifted. A frame of any other length changes no register.
- R2: Frame layout, MSB first: bit 23 read/write, bit 22 reserved (ignored), bits 21:19 register select, bits 18:16 channel/function address, bits 15:0 data. A frame with bit 23 = 1 (read) changes no register.
- R3: Register select 010 writes bits 15:0 into the input register of the addressed channel. The DAC output code does not change on such a write.
- R4: Channel address 000 selects channel A, 001 selects channel B, and 100 selects both. Data and gain writes with any other address change nothing.
- R5: Register select 000 with function address 101 (load) copies every channel's input register into its DAC register. The data bits are ignored.
- R6: Register select 000 with function address 100 (clear) sets every DAC register to 0 and leaves the input registers unchanged. The data bits are ignored.
- R7: `dac_code_o` for each channel is the DAC register XOR 16'h8000 when `twos_comp_i` = 1, and the DAC register unchanged when `twos_comp_i` = 0. A cleared channel therefore shows 16'h8000 in twos-complement coding and 16'h0000 in binary coding.
- R8: Register select 011 writes data bits 1:0 into the coarse-gain register of the addressed channel, and bits 15:2 are ignored. Code 00 is the default range, and 01 and 10 select wider ranges.
- R9: Register select 000 with function address 001 writes the configuration bits. Bit 5 drives `lgo_en_o`, bit 4 is pin 1 direction, bit 3 is pin 1 value, bit 2 is pin 0 direction, bit 1 is pin 0 value, and bit 0 is the serial-output disable. `sdo_oe_o` is the inverse of bit 0.
- R10: `gpio_oe_o[i]` follows pin i's direction bit. When that bit is 1, `gpio_out_o[i]` carries the written value bit. When that bit is 0, the value bit follows `gpio_in_i[i]` one clock later and written value data is ignored.
- R11: Function address 000 (no-operation) and the unused function addresses 010, 011, 110 and 111 change nothing. Register selects other than 000, 010 and 011 change nothing.
- R12: After reset, all input, DAC, gain and configuration registers are 0. So `sdo_oe_o` = 1, both pins are inputs, and `lgo_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | Serial clock, idles high; data is taken on its falling edge |
| spi_sync_n_i | input | 1 | Frame sync, active low |
| spi_sdi_i | input | 1 | Serial data in |
| twos_comp_i | input | 1 | 1 = twos-complement coding, 0 = straight binary |
| gpio_in_i | input | 2 | Sensed level of the two general-purpose pins |
| dac_code_o | output | 32 | Converter codes; channel A in bits 15:0, channel B in bits 31:16 |
| gain_o | output | 4 | Coarse gain; channel A in bits 1:0, channel B in bits 3:2 |
| lgo_en_o | output | 1 | Local-ground-offset adjust enable |
| gpio_oe_o | output | 2 | Pin output enables (direction bits) |
| gpio_out_o | output | 2 | Pin value bits |
| sdo_oe_o | output | 1 | Serial data output enable; low means high impedance |

## Verification
The bench builds the block with its default parameters: 16-bit codes, two channels and 2-bit gains. These values make the 24-bit frame, the broadcast address 100 and the 16'h8000 coding offset all reachable. The random part mixes valid and invalid register selects, channel addresses, read bits and frame lengths from 20 to 28. It also toggles the coding input and the pin levels, which brings load-after-clear, broadcast writes and input-pin tracking under the reference model. Directed frames cover frames one bit short and one bit long, clear in both codings, and gain writes with the upper data bits set.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    // register-select field values
    localparam logic [2:0] SEL_FUNC = 3'b000;
    localparam logic [2:0] SEL_DATA = 3'b010;
    localparam logic [2:0] SEL_GAIN = 3'b011;

    // function-register addresses
    localparam logic [2:0] FN_NOP   = 3'b000;
    localparam logic [2:0] FN_CFG   = 3'b001;
    localparam logic [2:0] FN_CLEAR = 3'b100;
    localparam logic [2:0] FN_LOAD  = 3'b101;

    // channel address that writes every channel
    localparam logic [2:0] CH_ALL   = 3'b100;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_COMMIT = 2'd2,
        RX_DROP   = 2'd3
    } rx_state_e;

    // configuration bits, MSB first, matching data bits 5..0
    typedef struct packed {
        logic lgo_en;
        logic p1_dir;
        logic p1_val;
        logic p0_dir;
        logic p0_val;
        logic sdo_dis;
    } cfg_t;

endpackage

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
    import dac_cmd_pkg::*;
#(
    parameter int FRAME_LEN = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sync_n_i,
    input  logic                 sdi_i,
    output logic [FRAME_LEN-1:0] frame_o,
    output logic                 frame_vld_o
);

    localparam int CNT_MAX = FRAME_LEN + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_e            state_q, state_d;
    logic                 sclk_q;
    logic                 sclk_fall;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [FRAME_LEN-1:0] shreg_q;

    assign sclk_fall = sclk_q & ~sclk_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (!sync_n_i) state_d = RX_SHIFT;
            RX_SHIFT:  if (sync_n_i)
                           state_d = (bit_cnt_q == CNT_W'(FRAME_LEN)) ? RX_COMMIT : RX_DROP;
            RX_COMMIT: state_d = RX_IDLE;
            RX_DROP:   state_d = RX_IDLE;
        endcase
    end

    // datapath: edge detect, shifter, saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b1;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
        end else begin
            sclk_q <= sclk_i;
            if (state_q == RX_IDLE) begin
                bit_cnt_q <= '0;
            end else if (state_q == RX_SHIFT && !sync_n_i && sclk_fall) begin
                shreg_q <= {shreg_q[FRAME_LEN-2:0], sdi_i};
                if (bit_cnt_q != CNT_W'(CNT_MAX)) begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        frame_o     = shreg_q;
        frame_vld_o = (state_q == RX_COMMIT);
    end

endmodule

// File: rtl/dac_func_regs.sv
module dac_func_regs
    import dac_cmd_pkg::*;
#(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cfg_i,
    input  cfg_t            wcfg_i,
    input  logic [NPIN-1:0] pin_in_i,
    output cfg_t            cfg_o
);

    cfg_t            cfg_q;
    logic [NPIN-1:0] new_dir;
    logic [NPIN-1:0] new_val;
    logic [NPIN-1:0] cur_dir;
    logic [NPIN-1:0] nxt_val;

    assign new_dir = {wcfg_i.p1_dir, wcfg_i.p0_dir};
    assign new_val = {wcfg_i.p1_val, wcfg_i.p0_val};
    assign cur_dir = {cfg_q.p1_dir, cfg_q.p0_dir};

    // value bit: written data when the pin is (or becomes) an output,
    // otherwise the sensed pin level
    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            if (wr_cfg_i) begin
                nxt_val[i] = new_dir[i] ? new_val[i] : pin_in_i[i];
            end else begin
                nxt_val[i] = cur_dir[i] ? (i == 0 ? cfg_q.p0_val : cfg_q.p1_val)
                                        : pin_in_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (wr_cfg_i) begin
                cfg_q.lgo_en  <= wcfg_i.lgo_en;
                cfg_q.p1_dir  <= wcfg_i.p1_dir;
                cfg_q.p0_dir  <= wcfg_i.p0_dir;
                cfg_q.sdo_dis <= wcfg_i.sdo_dis;
            end
            cfg_q.p0_val <= nxt_val[0];
            cfg_q.p1_val <= nxt_val[1];
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
    parameter int DW = 16,
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data_i,
    input  logic          wr_gain_i,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          twos_i,
    output logic [DW-1:0] code_o,
    output logic [GW-1:0] gain_o
);

    localparam logic [DW-1:0] SIGN_FLIP = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] in_q;
    logic [DW-1:0] dac_q;
    logic [GW-1:0] gain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q   <= '0;
            dac_q  <= '0;
            gain_q <= '0;
        end else begin
            if (wr_data_i) in_q   <= wdata_i;
            if (wr_gain_i) gain_q <= wdata_i[GW-1:0];
            if (clear_i) begin
                dac_q <= '0;
            end else if (load_i) begin
                dac_q <= in_q;
            end
        end
    end

    assign code_o = twos_i ? (dac_q ^ SIGN_FLIP) : dac_q;
    assign gain_o = gain_q;

endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
    import dac_cmd_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 2,
    parameter int GW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_sync_n_i,
    input  logic              spi_sdi_i,
    input  logic              twos_comp_i,
    input  logic [1:0]        gpio_in_i,
    output logic [NCH*DW-1:0] dac_code_o,
    output logic [NCH*GW-1:0] gain_o,
    output logic              lgo_en_o,
    output logic [1:0]        gpio_oe_o,
    output logic [1:0]        gpio_out_o,
    output logic              sdo_oe_o
);

    localparam int FL     = DW + 8;
    localparam int RW_BIT = FL - 1;
    localparam int SEL_LO = DW + 3;
    localparam int ADR_LO = DW;

    logic [FL-1:0] rx_frame;
    logic          rx_vld;
    logic          wr_ok;
    logic [2:0]    f_sel;
    logic [2:0]    f_adr;
    logic [DW-1:0] f_dat;
    logic          do_cfg;
    logic          do_load;
    logic          do_clear;
    cfg_t          cfg;

    dac_spi_rx #(.FRAME_LEN(FL)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk_i),
        .sync_n_i    (spi_sync_n_i),
        .sdi_i       (spi_sdi_i),
        .frame_o     (rx_frame),
        .frame_vld_o (rx_vld)
    );

    assign f_sel = rx_frame[SEL_LO +: 3];
    assign f_adr = rx_frame[ADR_LO +: 3];
    assign f_dat = rx_frame[DW-1:0];
    assign wr_ok = rx_vld && !rx_frame[RW_BIT];

    assign do_cfg   = wr_ok && f_sel == SEL_FUNC && f_adr == FN_CFG;
    assign do_clear = wr_ok && f_sel == SEL_FUNC && f_adr == FN_CLEAR;
    assign do_load  = wr_ok && f_sel == SEL_FUNC && f_adr == FN_LOAD;

    dac_func_regs #(.NPIN(2)) u_func (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg_i (do_cfg),
        .wcfg_i   (cfg_t'(f_dat[5:0])),
        .pin_in_i (gpio_in_i),
        .cfg_o    (cfg)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = (f_adr == 3'(ch)) || (f_adr == CH_ALL);

        dac_chan_regs #(.DW(DW), .GW(GW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_data_i (wr_ok && f_sel == SEL_DATA && hit),
            .wr_gain_i (wr_ok && f_sel == SEL_GAIN && hit),
            .load_i    (do_load),
            .clear_i   (do_clear),
            .wdata_i   (f_dat),
            .twos_i    (twos_comp_i),
            .code_o    (dac_code_o[ch*DW +: DW]),
            .gain_o    (gain_o[ch*GW +: GW])
        );
    end

    assign lgo_en_o   = cfg.lgo_en;
    assign gpio_oe_o  = {cfg.p1_dir, cfg.p0_dir};
    assign gpio_out_o = {cfg.p1_val, cfg.p0_val};
    assign sdo_oe_o   = !cfg.sdo_dis;

endmodule

// File: rtl/dac_cmd_checks.sv
module dac_cmd_checks #(
    parameter int DW  = 16,
    parameter int NCH = 2,
    parameter int GW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_vld,
    input logic [DW+7:0]     rx_frame,
    input logic              twos_comp_i,
    input logic [1:0]        gpio_in_i,
    input logic [NCH*DW-1:0] dac_code_o,
    input logic [NCH*GW-1:0] gain_o,
    input logic [1:0]        gpio_oe_o,
    input logic [1:0]        gpio_out_o,
    input logic              sdo_oe_o
);

    localparam int FL = DW + 8;

    logic is_write;
    logic is_func;
    assign is_write = rx_vld && !rx_frame[FL-1];
    assign is_func  = is_write && rx_frame[FL-3 -: 3] == 3'b000;

    AST_SDO_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_func && rx_frame[DW +: 3] == 3'b001) |=> (sdo_oe_o == !$past(rx_frame[0]))) // R9
        else $error("sdo enable mismatch");

    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_func && rx_frame[DW +: 3] == 3'b100) |=>
            (dac_code_o[DW-1:0] == {twos_comp_i, {(DW-1){1'b0}}})) // R6
        else $error("clear value mismatch");

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |=> ($stable(dac_code_o) || !$stable(twos_comp_i))) // R3
        else $error("code moved without a frame");

    AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_frame[FL-1]) |=> ($stable(gain_o) && $stable(gpio_oe_o) && $stable(sdo_oe_o))) // R2
        else $error("read frame changed state");

    for (genvar p = 0; p < 2; p++) begin : g_pin
        AST_PIN_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_vld && !gpio_oe_o[p]) |=> (gpio_out_o[p] == $past(gpio_in_i[p]))) // R10
            else $error("input pin not tracked");
    end

endmodule

bind dac_cmd_core dac_cmd_checks #(.DW(DW), .NCH(NCH), .GW(GW)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_vld      (rx_vld),
    .rx_frame    (rx_frame),
    .twos_comp_i (twos_comp_i),
    .gpio_in_i   (gpio_in_i),
    .dac_code_o  (dac_code_o),
    .gain_o      (gain_o),
    .gpio_oe_o   (gpio_oe_o),
    .gpio_out_o  (gpio_out_o),
    .sdo_oe_o    (sdo_oe_o)
);

// File: tb/dac_cmd_core_bench.sv
module dac_cmd_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NCH = 2;
    localparam int GW = 2;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sync_n = 1'b1;
    logic sdi = 1'b0;
    logic twos = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [NCH*DW-1:0] code;
    logic [NCH*GW-1:0] gain;
    logic lgo;
    logic [1:0] oe;
    logic [1:0] pout;
    logic sdo_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // reference model
    logic [DW-1:0] m_in  [NCH];
    logic [DW-1:0] m_dac [NCH];
    logic [GW-1:0] m_gain[NCH];
    logic [5:0]    m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_core #(.DW(DW), .NCH(NCH), .GW(GW)) u_dac_cmd_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk_i   (sclk),
        .spi_sync_n_i (sync_n),
        .spi_sdi_i    (sdi),
        .twos_comp_i  (twos),
        .gpio_in_i    (pin_in),
        .dac_code_o   (code),
        .gain_o       (gain),
        .lgo_en_o     (lgo),
        .gpio_oe_o    (oe),
        .gpio_out_o   (pout),
        .sdo_oe_o     (sdo_oe)
    );

    function automatic logic [DW-1:0] exp_code(input logic [DW-1:0] r, input logic tc);
        return tc ? (r ^ 16'h8000) : r;
    endfunction

    function automatic logic [23:0] mk(input logic [2:0] sel, input logic [2:0] adr,
                                       input logic [15:0] dat);
        return {1'b0, 1'b0, sel, adr, dat};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_in[c] = '0; m_dac[c] = '0; m_gain[c] = '0;
        end
        m_cfg = '0;
    endtask

    task automatic model_apply(input logic [23:0] f, input int len);
        logic [2:0] sel, adr;
        logic [15:0] d;
        sel = f[21:19]; adr = f[18:16]; d = f[15:0];
        if (len != 24 || f[23]) return;
        if (sel == 3'b000) begin
            if (adr == 3'b001) m_cfg = d[5:0];
            else if (adr == 3'b100) for (int c = 0; c < NCH; c++) m_dac[c] = '0;
            else if (adr == 3'b101) for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
        end else if (sel == 3'b010 || sel == 3'b011) begin
            for (int c = 0; c < NCH; c++) begin
                if (adr == 3'(c) || adr == 3'b100) begin
                    if (sel == 3'b010) m_in[c] = d;
                    else m_gain[c] = d[1:0];
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        logic [NCH*DW-1:0] e_code;
        logic [NCH*GW-1:0] e_gain;
        logic [1:0] e_oe, e_out;
        for (int c = 0; c < NCH; c++) begin
            e_code[c*DW +: DW] = exp_code(m_dac[c], twos);
            e_gain[c*GW +: GW] = m_gain[c];
        end
        e_oe  = {m_cfg[4], m_cfg[2]};
        e_out = {m_cfg[4] ? m_cfg[3] : pin_in[1], m_cfg[2] ? m_cfg[1] : pin_in[0]};
        n_checks++;
        if (code !== e_code || gain !== e_gain || lgo !== m_cfg[5] || oe !== e_oe ||
            pout !== e_out || sdo_oe !== !m_cfg[0]) begin
            n_errors++;
            $display("FAIL %s: code=%h gain=%b lgo=%b oe=%b out=%b sdo_oe=%b expected code=%h gain=%b lgo=%b oe=%b out=%b sdo_oe=%b",
                     tag, code, gain, lgo, oe, pout, sdo_oe,
                     e_code, e_gain, m_cfg[5], e_oe, e_out, !m_cfg[0]);
        end
    endtask

    task automatic send(input logic [31:0] v, input int n);
        sync_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (2) @(negedge clk);
        sync_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [23:0] f, input int len, input string tag);
        logic [31:0] v;
        v = {8'h00, f};
        if (len > 24) v = {f, 8'h5A} >> (32 - len);
        send(v, len);
        model_apply(f, len);
        check_all(tag);
    endtask

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1D5E_7A21;
        void'($urandom(seed));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R12 reset state");

        // R3: data write does not move the output
        frame(mk(3'b010, 3'b000, 16'h1234), 24, "R3 data write A staged");
        // R5: load
        frame(mk(3'b000, 3'b101, 16'hFFFF), 24, "R5 load");
        // R4: channel B, both, invalid addresses
        frame(mk(3'b010, 3'b001, 16'hBEEF), 24, "R4 channel B");
        frame(mk(3'b010, 3'b010, 16'h0BAD), 24, "R4 invalid address 010");
        frame(mk(3'b010, 3'b111, 16'h0BAD), 24, "R4 invalid address 111");
        frame(mk(3'b000, 3'b101, 16'h0000), 24, "R5 load both");
        frame(mk(3'b010, 3'b100, 16'h7001), 24, "R4 broadcast data");
        // R1: wrong lengths ignored
        frame(mk(3'b000, 3'b101, 16'h0000), 23, "R1 short frame");
        frame(mk(3'b000, 3'b101, 16'h0000), 25, "R1 long frame");
        // R2: read frame ignored
        frame({1'b1, 1'b0, 3'b000, 3'b101, 16'h0000}, 24, "R2 read frame");
        frame({1'b0, 1'b1, 3'b000, 3'b101, 16'h0000}, 24, "R2 reserved bit ignored");
        // R6/R7: clear in both codings
        twos = 1'b1;
        @(negedge clk);
        check_all("R7 twos coding view");
        frame(mk(3'b000, 3'b100, 16'hFFFF), 24, "R6 clear twos");
        twos = 1'b0;
        @(negedge clk);
        check_all("R6 clear binary");
        frame(mk(3'b000, 3'b101, 16'h0000), 24, "R6 inputs kept after clear");
        // R8: gain with upper bits set
        frame(mk(3'b011, 3'b000, 16'hFFFE), 24, "R8 gain A 10");
        frame(mk(3'b011, 3'b001, 16'hAAA1), 24, "R8 gain B 01");
        // R9/R10: configuration and pins
        frame(mk(3'b000, 3'b001, 16'h003F), 24, "R9 cfg all set");
        frame(mk(3'b000, 3'b001, 16'h0014), 24, "R10 outputs value 0");
        pin_in = 2'b11;
        frame(mk(3'b000, 3'b001, 16'h000A), 24, "R10 input ignores written value");
        pin_in = 2'b01;
        repeat (3) @(negedge clk);
        check_all("R10 input tracks pin");
        // R11: nop and unused
        frame(mk(3'b000, 3'b000, 16'hFFFF), 24, "R11 nop");
        frame(mk(3'b000, 3'b110, 16'hFFFF), 24, "R11 unused function");
        frame(mk(3'b001, 3'b000, 16'hFFFF), 24, "R11 unused select");
        frame(mk(3'b111, 3'b100, 16'hFFFF), 24, "R11 unused select 111");

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [23:0] f;
            logic [2:0] sel, adr;
            int len, r;
            r = $urandom_range(0, 9);
            sel = (r < 3) ? 3'b010 : (r < 5) ? 3'b011 : (r < 8) ? 3'b000 : 3'($urandom);
            r = $urandom_range(0, 9);
            if (sel == 3'b000)
                adr = (r < 3) ? 3'b001 : (r < 5) ? 3'b101 : (r < 7) ? 3'b100 : 3'($urandom);
            else
                adr = (r < 4) ? 3'b000 : (r < 7) ? 3'b001 : (r < 9) ? 3'b100 : 3'($urandom);
            f = {($urandom_range(0, 9) == 0), 1'($urandom), sel, adr, 16'($urandom)};
            len = ($urandom_range(0, 9) == 0) ? $urandom_range(20, 28) : 24;
            if ($urandom_range(0, 7) == 0) twos = ~twos;
            if ($urandom_range(0, 3) == 0) pin_in = 2'($urandom);
            repeat (2) @(negedge clk);
            frame(f, len, "R1 R3 R4 R5 R6 R8 R9 R10 random frame");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule